// File: doc/BRIEF.md
# Configuration frame deserializer

This block takes over the configuration byte stream once the command parser has recognised the frame-programming opcode. It first reads a three-byte setup header. The header says how many frames follow, whether checksums are compared, whether they are compared after every frame or only once after the last one, and how many filler bytes separate frames. The block then packs the bytes into fixed-length configuration frames and writes each completed frame to frame memory. The address of each write is one lower than the one before.

Within each byte the bits arrive least significant first relative to the frame. Bit 0 of the first byte of a frame is the frame's most significant bit. A frame occupies a whole number of bytes. Any pad bits at its tail are dropped. The data-bit and pad-bit counts are parameters.

The checksum arithmetic is not done here. The block tells an external CRC accumulator which bytes to absorb. It also captures each received 16-bit checksum and presents it with a one-cycle compare strobe. When the last frame is complete, the block pulses a completion strobe and hands control back to the command parser.

Top module: `cfg_frame_deser`

## Requirements
- R1: While reset is held and after it is released, `busy`, `frameWrStb`, `crcCheckStb` and `doneStb` are all low until `start` is seen.
- R2: A `start` pulse while idle makes `busy` high from the next cycle. The next three accepted bytes form the header, most significant byte first. A `start` seen while busy has no effect.
- R3: Bit j of frame byte k (k = 0 first, j = 0..7) becomes stream bit 8k+j. Stream bit 0 is the most significant frame bit. `frameWrData` holds the first DATA_BITS stream bits, and the trailing PAD_BITS are discarded.
- R4: `frameWrStb` is high for exactly one cycle, the cycle after the edge that accepts a frame's last byte. The frame word and address are valid in that cycle.
- R5: The first frame is written at address N-1, where N is header bits 15:0. Each later frame is written one address lower.
- R6: With header bit 23 = 1 and bit 22 = 0, two checksum bytes (high byte first) follow every frame. In the cycle after the second one, `crcCheckStb` pulses for one cycle and `crcExpected` holds the checksum.
- R7: With header bit 22 = 1, checksum bytes follow only the last frame, and only one compare strobe is given.
- R8: With header bit 23 = 0, the checksum bytes are still consumed, but `crcCheckStb` never rises.
- R9: Between frames (never after the last), the block skips F filler bytes, where F is header bits 19:16. If header bit 20 = 1, F is taken as 0.
- R10: `crcFeed` is high in the same cycle as an accepted header or frame byte. It is low for checksum and filler bytes.
- R11: `doneStb` pulses once, in the cycle after the final byte: the last checksum byte, or the third header byte when N = 0. `busy` is low from that cycle on.
- R12: Header bit 21 is ignored. A stream that differs only in that bit produces the same writes, strobes and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Hand-over pulse from the command parser |
| inValid | input | 1 | A stream byte is present on `inData` this cycle |
| inData | input | 8 | Stream byte |
| busy | output | 1 | Block owns the stream |
| crcFeed | output | 1 | Current byte must be absorbed by the CRC accumulator |
| frameWrStb | output | 1 | One-cycle frame write strobe |
| frameWrAddr | output | 16 | Frame address for the write |
| frameWrData | output | DATA_BITS | Assembled frame word |
| crcCheckStb | output | 1 | One-cycle compare request to the CRC accumulator |
| crcExpected | output | 16 | Checksum received from the stream |
| doneStb | output | 1 | One-cycle completion pulse |

## Verification
`crcFeed` is combinational, so it is checked shortly after a byte is driven and before the edge that accepts it. The write, compare and completion strobes each pass through one register. They are due exactly one cycle after the accepting edge, and they are sampled on the falling edge that follows it. When the stream pauses after a byte, the next falling edge is also checked, and every strobe must be low there. Each stimulus byte carries its own expected strobes and values, worked out from the header fields. A strobe that arrives early, late or twice shows up against the byte it belongs to.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_CRC,
    ST_FILL
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hdrLd;
    logic dataLd;
    logic crcLd;
    logic addrLd;
    logic addrDec;
  } dpStrobe_t;

  // header fields the control needs once the header is in
  typedef struct packed {
    logic       cmpEn;
    logic       atEnd;
    logic       noFill;
    logic [3:0] fillCnt;
  } runCfg_t;

endpackage

// File: rtl/cfd_datapath.sv
module cfd_datapath
  import cfd_pkg::*;
#(
  parameter int DATA_BITS = 22,
  parameter int PAD_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [7:0]           inData,
  output logic [CNT_W-1:0]     hdrCount,
  output runCfg_t              cfg,
  output logic [DATA_BITS-1:0] frameWord,
  output logic [CNT_W-1:0]     frameAddr,
  output logic [15:0]          crcWord
);

  localparam int TOT_BITS    = DATA_BITS + PAD_BITS;
  localparam int FRAME_BYTES = TOT_BITS / 8;

  logic [23:0]        hdrReg;
  logic [23:0]        hdrNext;
  logic [7:0]         revByte;
  logic [TOT_BITS-1:0] frameSh;
  logic               unusedRsvd;

  assign hdrNext   = {hdrReg[15:0], inData};
  assign hdrCount  = hdrNext[CNT_W-1:0];
  assign cfg       = '{cmpEn: hdrReg[23], atEnd: hdrReg[22], noFill: hdrReg[20],
                       fillCnt: hdrReg[19:16]};
  assign unusedRsvd = hdrReg[21];

  // bit 0 of an incoming byte is the earliest (most significant) frame bit
  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign revByte[i] = inData[7-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg  <= '0;
      crcWord <= '0;
    end else begin
      if (strb.hdrLd) hdrReg  <= hdrNext;
      if (strb.crcLd) crcWord <= {crcWord[7:0], inData};
    end
  end

  if (FRAME_BYTES == 1) begin : g_oneByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            frameSh <= '0;
      else if (strb.dataLd) frameSh <= revByte;
    end
  end else begin : g_multiByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            frameSh <= '0;
      else if (strb.dataLd) frameSh <= {frameSh[TOT_BITS-9:0], revByte};
    end
  end

  assign frameWord = frameSh[TOT_BITS-1 -: DATA_BITS];

  if (PAD_BITS > 0) begin : g_pad
    logic unusedPad;
    assign unusedPad = ^frameSh[PAD_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              frameAddr <= '0;
    else if (strb.addrLd)   frameAddr <= hdrNext[CNT_W-1:0] - CNT_W'(1);
    else if (strb.addrDec)  frameAddr <= frameAddr - CNT_W'(1);
  end

  // R10
  ld_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.hdrLd, strb.dataLd, strb.crcLd}));

endmodule

// File: rtl/cfd_control.sv
module cfd_control
  import cfd_pkg::*;
#(
  parameter int FRAME_BYTES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inValid,
  input  logic [CNT_W-1:0] hdrCount,
  input  runCfg_t          cfg,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             crcFeed,
  output logic             wrStb,
  output logic             chkStb,
  output logic             doneStb
);

  localparam int CMAX = (FRAME_BYTES > 16) ? FRAME_BYTES : 16;
  localparam int CW   = $clog2(CMAX);
  localparam logic [CW-1:0] LAST_DATA = CW'(FRAME_BYTES - 1);

  phase_e           state;
  logic [CW-1:0]    byteCnt;
  logic [CNT_W-1:0] framesLeft;
  logic             take;
  logic             lastFrame;
  logic [3:0]       fillN;

  assign take      = inValid && (state != ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign lastFrame = (framesLeft == CNT_W'(1));
  assign fillN     = cfg.noFill ? 4'd0 : cfg.fillCnt;

  always_comb begin
    strb.hdrLd   = take && (state == ST_HDR);
    strb.dataLd  = take && (state == ST_DATA);
    strb.crcLd   = take && (state == ST_CRC);
    strb.addrLd  = take && (state == ST_HDR) && (byteCnt == CW'(2));
    strb.addrDec = wrStb;
    crcFeed      = strb.hdrLd || strb.dataLd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      byteCnt    <= '0;
      framesLeft <= '0;
      wrStb      <= 1'b0;
      chkStb     <= 1'b0;
      doneStb    <= 1'b0;
    end else begin
      wrStb   <= 1'b0;
      chkStb  <= 1'b0;
      doneStb <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_HDR;
            byteCnt <= '0;
          end
        end
        ST_HDR: begin
          if (take) begin
            if (byteCnt == CW'(2)) begin
              byteCnt    <= '0;
              framesLeft <= hdrCount;
              if (hdrCount == '0) begin
                doneStb <= 1'b1;
                state   <= ST_IDLE;
              end else begin
                state   <= ST_DATA;
              end
            end else begin
              byteCnt <= byteCnt + CW'(1);
            end
          end
        end
        ST_DATA: begin
          if (take) begin
            if (byteCnt == LAST_DATA) begin
              wrStb      <= 1'b1;
              byteCnt    <= '0;
              framesLeft <= framesLeft - CNT_W'(1);
              if (!cfg.atEnd || lastFrame) state <= ST_CRC;
              else if (fillN != 4'd0)      state <= ST_FILL;
              else                         state <= ST_DATA;
            end else begin
              byteCnt <= byteCnt + CW'(1);
            end
          end
        end
        ST_CRC: begin
          if (take) begin
            if (byteCnt == CW'(1)) begin
              chkStb  <= cfg.cmpEn;
              byteCnt <= '0;
              if (framesLeft == '0) begin
                doneStb <= 1'b1;
                state   <= ST_IDLE;
              end else if (fillN != 4'd0) begin
                state   <= ST_FILL;
              end else begin
                state   <= ST_DATA;
              end
            end else begin
              byteCnt <= byteCnt + CW'(1);
            end
          end
        end
        ST_FILL: begin
          if (take) begin
            if (byteCnt == CW'(fillN - 4'd1)) begin
              byteCnt <= '0;
              state   <= ST_DATA;
            end else begin
              byteCnt <= byteCnt + CW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (state == ST_IDLE));

  // R2
  start_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_HDR) && ($past(state) == ST_IDLE)) |-> $past(start));

  // R8
  chk_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkStb |-> cfg.cmpEn);

  // R6
  chk_write_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkStb |-> !wrStb);

endmodule

// File: rtl/cfg_frame_deser.sv
module cfg_frame_deser
  import cfd_pkg::*;
#(
  parameter int DATA_BITS = 22,
  parameter int PAD_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 inValid,
  input  logic [7:0]           inData,
  output logic                 busy,
  output logic                 crcFeed,
  output logic                 frameWrStb,
  output logic [15:0]          frameWrAddr,
  output logic [DATA_BITS-1:0] frameWrData,
  output logic                 crcCheckStb,
  output logic [15:0]          crcExpected,
  output logic                 doneStb
);

  localparam int FRAME_BYTES = (DATA_BITS + PAD_BITS) / 8;

  dpStrobe_t        strb;
  runCfg_t          cfg;
  logic [CNT_W-1:0] hdrCount;

  cfd_control #(
    .FRAME_BYTES(FRAME_BYTES)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .hdrCount (hdrCount),
    .cfg      (cfg),
    .strb     (strb),
    .busy     (busy),
    .crcFeed  (crcFeed),
    .wrStb    (frameWrStb),
    .chkStb   (crcCheckStb),
    .doneStb  (doneStb)
  );

  cfd_datapath #(
    .DATA_BITS(DATA_BITS),
    .PAD_BITS (PAD_BITS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inData    (inData),
    .hdrCount  (hdrCount),
    .cfg       (cfg),
    .frameWord (frameWrData),
    .frameAddr (frameWrAddr),
    .crcWord   (crcExpected)
  );

endmodule

// File: tb/cfg_frame_deser_bench.sv
`timescale 1ns/1ps
module cfg_frame_deser_bench;

  localparam int DATA_BITS = 22;
  localparam int PAD_BITS  = 2;
  localparam int TOT       = DATA_BITS + PAD_BITS;
  localparam int FB        = TOT / 8;
  localparam int NSCEN     = 7;

  // header per scenario: [23] compare, [22] at end, [21] ignored,
  // [20] no filler, [19:16] filler count, [15:0] frame count
  localparam logic [23:0] SCEN [NSCEN] = '{
    24'h81_0003, 24'hC1_0004, 24'h02_0002, 24'h93_0003,
    24'hA1_0002, 24'h80_0000, 24'h80_0001
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic busy, crcFeed, frameWrStb, crcCheckStb, doneStb;
  logic [15:0] frameWrAddr, crcExpected;
  logic [DATA_BITS-1:0] frameWrData;

  always #2 clk = ~clk;

  cfg_frame_deser #(.DATA_BITS(DATA_BITS), .PAD_BITS(PAD_BITS)) u_cfg_frame_deser (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inData(inData),
    .busy(busy), .crcFeed(crcFeed), .frameWrStb(frameWrStb),
    .frameWrAddr(frameWrAddr), .frameWrData(frameWrData),
    .crcCheckStb(crcCheckStb), .crcExpected(crcExpected), .doneStb(doneStb)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0]           sByte [64];
  bit                   sFeed [64];
  bit                   sFill [64];
  bit                   sWr   [64];
  bit                   sChk  [64];
  bit                   sDone [64];
  logic [15:0]          sAddr [64];
  logic [15:0]          sCrc  [64];
  logic [DATA_BITS-1:0] sData [64];
  int sLen;
  int wrSeen;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic push(input logic [7:0] b, input bit feed, input bit fill);
    sByte[sLen] = b;  sFeed[sLen] = feed; sFill[sLen] = fill;
    sWr[sLen] = 1'b0; sChk[sLen] = 1'b0;  sDone[sLen] = 1'b0;
    sAddr[sLen] = '0; sCrc[sLen] = '0;    sData[sLen] = '0;
    sLen++;
  endtask

  task automatic buildScenario(input logic [23:0] h, input int s);
    int count;
    int nFill;
    logic [DATA_BITS-1:0] fv;
    logic [TOT-1:0] vec;
    logic [15:0] cv;
    bit last;
    sLen = 0;
    count = int'(h[15:0]);
    nFill = h[20] ? 0 : int'(h[19:16]);
    push(h[23:16], 1'b1, 1'b0);
    push(h[15:8], 1'b1, 1'b0);
    push(h[7:0], 1'b1, 1'b0);
    if (count == 0) sDone[sLen-1] = 1'b1;
    for (int f = 0; f < count; f++) begin
      last = (f == count - 1);
      fv  = DATA_BITS'((s * 40503 + f * 9973) ^ 32'h2A5A5);
      vec = {fv, PAD_BITS'(f + 1)};
      for (int k = 0; k < FB; k++) push(rev8(vec[TOT-1-8*k -: 8]), 1'b1, 1'b0);
      sWr[sLen-1]   = 1'b1;
      sAddr[sLen-1] = 16'(count - 1 - f);
      sData[sLen-1] = fv;
      if (!h[22] || last) begin
        cv = 16'((s * 4099 + f * 311) ^ 16'hC35A);
        push(cv[15:8], 1'b0, 1'b0);
        push(cv[7:0], 1'b0, 1'b0);
        sChk[sLen-1] = h[23];
        sCrc[sLen-1] = cv;
        if (last) sDone[sLen-1] = 1'b1;
      end
      if (!last) for (int n = 0; n < nFill; n++) push(8'hFF, 1'b0, 1'b1);
    end
  endtask

  task automatic runStream(input logic [23:0] h, input bit gaps, input int startAt);
    string chkTag;
    string runTag;
    chkTag = h[22] ? "R7" : (h[23] ? "R6" : "R8");
    runTag = (startAt >= 0) ? "R2" : (h[21] ? "R12" : (h[20] ? "R9" : "R5"));
    wrSeen = 0;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 64'(busy), 64'd1);
    for (int i = 0; i < sLen; i++) begin
      inValid = 1'b1;
      inData  = sByte[i];
      start   = (i == startAt);
      #1;
      chk(sFill[i] ? "R9 feed" : "R10 feed", 64'(crcFeed), 64'(sFeed[i]));
      @(posedge clk); @(negedge clk);
      inValid = 1'b0;
      start   = 1'b0;
      if (frameWrStb) wrSeen++;
      chk(sFill[i] ? "R9 write strobe" : "R4 write strobe", 64'(frameWrStb), 64'(sWr[i]));
      if (sWr[i]) begin
        chk("R3 frame data", 64'(frameWrData), 64'(sData[i]));
        chk("R5 frame addr", 64'(frameWrAddr), 64'(sAddr[i]));
      end
      chk(chkTag, 64'(crcCheckStb), 64'(sChk[i]));
      if (sChk[i]) chk("R6 crc value", 64'(crcExpected), 64'(sCrc[i]));
      chk("R11 done strobe", 64'(doneStb), 64'(sDone[i]));
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); @(negedge clk);
        chk("R4 single cycle", 64'({frameWrStb, crcCheckStb, doneStb}), 64'd0);
      end
    end
    chk("R11 idle after done", 64'(busy), 64'd0);
    chk(runTag, 64'(wrSeen), 64'(h[15:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 strobes in reset", 64'({frameWrStb, crcCheckStb, doneStb}), 64'd0);
    rstN = 1'b1;
    // bytes before start are not taken
    inValid = 1'b1; inData = 8'h81;
    #1 chk("R1 feed while idle", 64'(crcFeed), 64'd0);
    repeat (2) @(negedge clk);
    inValid = 1'b0;
    chk("R1 busy idle", 64'(busy), 64'd0);
    chk("R1 strobes idle", 64'({frameWrStb, crcCheckStb, doneStb}), 64'd0);

    for (int s = 0; s < NSCEN; s++) begin
      buildScenario(SCEN[s], s);
      runStream(SCEN[s], (s % 2) == 1, (s == 0) ? 5 : -1);
      repeat (2) @(negedge clk);
    end

    // R12: same stream with bit 21 toggled gives same result
    buildScenario(24'h81_0002 ^ 24'h20_0000, 4);
    runStream(24'h81_0002 ^ 24'h20_0000, 1'b0, -1);
    buildScenario(24'h81_0002, 4);
    runStream(24'h81_0002, 1'b0, -1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule